// File: doc/BRIEF.md
# CAN Fault Confinement Status Unit

This block tracks the two error counters of a CAN node and turns them into the node's fault-confinement state: error active, error passive or bus-off. The transmit counter is 9 bits wide so that it can go past 255, which is the event that forces bus-off. The receive counter stops at 255. A bit engine outside this block pulses increment and decrement strobes. The size of each step that a CAN error causes is decided outside this block, so each strobe moves a counter by exactly one.

Three sticky status flags record entry into receiver-passive, transmitter-passive and bus-off. Software clears them by writing ones to a clear port. While the bus-off flag is set, both passive flags are blocked from setting. While the node stays in bus-off, a clear of the bus-off flag is refused. The node stays in bus-off until it has seen 128 runs of eleven recessive bits on the sampled bus. When recovery completes, both counters return to zero and the node becomes error active again. One error interrupt line is the OR of all flags whose enable bit is set. A soft-reset input holds the whole unit in its reset state.

Top module: `can_fault_conf`

## Requirements
- R1: The transmit counter `tec_o` (9 bits) adds one on a cycle with `tec_inc_i` high and `tec_dec_i` low, and subtracts one in the opposite case. When both or neither strobe is high it keeps its value. It saturates at 0 and 511, and it is frozen while the counter is above 255 or the node is in bus-off.
- R2: The receive counter `rec_o` (8 bits) follows the same strobe rules with `rec_inc_i`/`rec_dec_i`. It saturates at 0 and 255, and it is frozen under the same conditions as R1.
- R3: `state_o` reads 2 in bus-off. Otherwise it reads 1 when either counter is at least 128, and 0 in all other cases. Bus-off begins at the clock edge after `tec_o` first exceeds 255.
- R4: Flag bit 0 (receiver passive) sets one edge after the condition "`rec_o` ≥ 128 and flag bit 2 clear" becomes true. It sets only on that rising condition.
- R5: Flag bit 1 (transmitter passive) sets one edge after the condition "128 ≤ `tec_o` ≤ 255 and flag bit 2 clear" becomes true. It sets only on that rising condition.
- R6: Flag bit 2 (bus-off) sets on the same edge on which `state_o` becomes 2.
- R7: Flags stay set until a one is written to the matching bit of `flag_clr_i`. If a set and a clear occur in the same cycle, the set wins.
- R8: A clear of flag bit 2 is ignored while `state_o` is 2.
- R9: In bus-off, each `bit_stb_i` with `bus_bit_i`=1 (recessive) adds to the current run, and a strobe with `bus_bit_i`=0 (dominant) restarts the run. Eleven recessive strobes complete a run. On the edge that completes the 128th run, both counters become 0 and `state_o` becomes 0. Flag bit 2 stays set.
- R10: `err_irq_o` is high, in the same cycle, whenever some flag bit and its `irq_en_i` bit are both high.
- R11: While `soft_rst_i` is high, the flags, both counters, the recovery progress and the state are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous hold-in-reset |
| tec_inc_i | input | 1 | Transmit counter increment strobe |
| tec_dec_i | input | 1 | Transmit counter decrement strobe |
| rec_inc_i | input | 1 | Receive counter increment strobe |
| rec_dec_i | input | 1 | Receive counter decrement strobe |
| bit_stb_i | input | 1 | One pulse per sampled bus bit |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| irq_en_i | input | 3 | Per-flag interrupt enable |
| flag_clr_i | input | 3 | Write-one-to-clear for flags |
| flags_o | output | 3 | {bus-off, tx passive, rx passive} |
| state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench drives the transmit counter across 255. A design that lets the counter keep moving in bus-off, or that enters bus-off one edge late, shows up there. It also tries to clear the bus-off flag during bus-off, which a design that does not gate the clear would lose. Recovery is driven with dominant bits that break runs and with sparse bit strobes, and the state is checked one recessive bit before the last run completes and again on that bit, which exposes an off-by-one run or bit count. After recovery the bus-off flag is still set, so the bench raises the receive counter to show that the passive flag stays blocked, then clears bus-off and expects the flag to set on the rising condition. A case with a clear and a set in the same cycle shows which one wins.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } fc_state_e;

  localparam int unsigned FL_RXP  = 0;
  localparam int unsigned FL_TXP  = 1;
  localparam int unsigned FL_BOFF = 2;
  localparam int unsigned NFLAG   = 3;
endpackage

// File: rtl/can_fc_satcnt.sv
module can_fc_satcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic do_up, do_dn;
  assign do_up = !hold_i && up_i && !dn_i && (cnt_o != MAXV);
  assign do_dn = !hold_i && dn_i && !up_i && (cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (do_up) cnt_o <= cnt_o + 1'b1;
    else if (do_dn) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int unsigned RUN_BITS = 11,
  parameter int unsigned RUNS     = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic busoff_i,
  input  logic bit_stb_i,
  input  logic bus_bit_i,
  output logic done_o
);
  localparam int unsigned BW = $clog2(RUN_BITS);
  localparam int unsigned RW = $clog2(RUNS);
  localparam logic [BW-1:0] BIT_LAST = BW'(RUN_BITS - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUNS - 1);

  logic [BW-1:0] bit_q;
  logic [RW-1:0] run_q;
  logic          run_end;

  assign run_end = busoff_i && bit_stb_i && bus_bit_i && (bit_q == BIT_LAST);
  assign done_o  = run_end && (run_q == RUN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (srst_i || !busoff_i) begin
      bit_q <= '0;
      run_q <= '0;
    end else if (bit_stb_i) begin
      if (!bus_bit_i) begin
        bit_q <= '0;               // dominant bit breaks the run
      end else if (run_end) begin
        bit_q <= '0;
        run_q <= done_o ? '0 : run_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] clr_ok_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic prev_q, flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else if (srst_i) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= cond_i[g];
        if (cond_i[g] && !prev_q)           flag_q <= 1'b1;  // set beats clear
        else if (clr_i[g] && clr_ok_i[g])   flag_q <= 1'b0;
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned TEC_W      = 9,
  parameter int unsigned REC_W      = 8,
  parameter int unsigned PASSIVE_AT = 128,
  parameter int unsigned BOFF_AT    = 256,
  parameter int unsigned RUN_BITS   = 11,
  parameter int unsigned RUNS       = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             tec_inc_i,
  input  logic             tec_dec_i,
  input  logic             rec_inc_i,
  input  logic             rec_dec_i,
  input  logic             bit_stb_i,
  input  logic             bus_bit_i,
  input  logic [NFLAG-1:0] irq_en_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [1:0]       state_o,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             err_irq_o
);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_AT);
  localparam logic [TEC_W-1:0] TEC_BOFF = TEC_W'(BOFF_AT);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_AT);

  logic             busoff_q, over_lim, hold, rcv_done, cnt_clr;
  logic             rx_pass, tx_pass;
  logic [NFLAG-1:0] cond, clr_ok;
  fc_state_e        st;

  assign over_lim = (tec_o >= TEC_BOFF);
  assign hold     = busoff_q || over_lim;
  assign cnt_clr  = soft_rst_i || rcv_done;
  assign rx_pass  = (rec_o >= REC_PASS);
  assign tx_pass  = (tec_o >= TEC_PASS) && !over_lim;

  can_fc_satcnt #(.W(TEC_W)) u_tec (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .hold_i(hold),
    .up_i(tec_inc_i), .dn_i(tec_dec_i), .cnt_o(tec_o)
  );

  can_fc_satcnt #(.W(REC_W)) u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .hold_i(hold),
    .up_i(rec_inc_i), .dn_i(rec_dec_i), .cnt_o(rec_o)
  );

  can_fc_recovery #(.RUN_BITS(RUN_BITS), .RUNS(RUNS)) u_rcv (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i), .busoff_i(busoff_q),
    .bit_stb_i(bit_stb_i), .bus_bit_i(bus_bit_i), .done_o(rcv_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     busoff_q <= 1'b0;
    else if (soft_rst_i || rcv_done) busoff_q <= 1'b0;
    else if (over_lim)               busoff_q <= 1'b1;
  end

  // passive entries are masked by the bus-off flag, not by the state
  always_comb begin
    cond          = '0;
    cond[FL_RXP]  = rx_pass && !flags_o[FL_BOFF];
    cond[FL_TXP]  = tx_pass && !flags_o[FL_BOFF];
    cond[FL_BOFF] = over_lim;
    clr_ok        = '1;
    clr_ok[FL_BOFF] = !busoff_q;
  end

  can_fc_flags #(.N(NFLAG)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(soft_rst_i), .cond_i(cond),
    .clr_i(flag_clr_i), .clr_ok_i(clr_ok), .flag_o(flags_o)
  );

  always_comb begin
    if (busoff_q)                      st = ST_BUSOFF;
    else if (rx_pass || (tec_o >= TEC_PASS)) st = ST_PASSIVE;
    else                               st = ST_ACTIVE;
  end

  assign state_o   = st;
  assign err_irq_o = |(flags_o & irq_en_i);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int unsigned TEC_W      = 9,
  parameter int unsigned REC_W      = 8,
  parameter int unsigned PASSIVE_AT = 128,
  parameter int unsigned BOFF_AT    = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic [2:0]       irq_en_i,
  input logic [2:0]       flags_o,
  input logic [1:0]       state_o,
  input logic [TEC_W-1:0] tec_o,
  input logic [REC_W-1:0] rec_o,
  input logic             err_irq_o
);
  localparam logic [TEC_W-1:0] TP = TEC_W'(PASSIVE_AT);
  localparam logic [TEC_W-1:0] TB = TEC_W'(BOFF_AT);
  localparam logic [REC_W-1:0] RP = REC_W'(PASSIVE_AT);

  p_boff_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd2) |-> (tec_o == $past(tec_o) && rec_o == $past(rec_o)));

  p_rxp_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[0]) |-> ($past(rec_o) >= RP && !$past(flags_o[2])));

  p_txp_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> ($past(tec_o) >= TP && $past(tec_o) < TB && !$past(flags_o[2])));

  p_boff_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (state_o != 2'd2 && tec_o >= TB) |=> (state_o == 2'd2 && flags_o[2]));

  p_boff_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (state_o == 2'd2 && flags_o[2]) |=> flags_o[2]);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_o & irq_en_i) == 3'b000) |-> !err_irq_o);

  p_soft_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (flags_o == 3'b000 && tec_o == '0 && rec_o == '0 && state_o == 2'd0));
endmodule

bind can_fault_conf can_fault_conf_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_AT(PASSIVE_AT), .BOFF_AT(BOFF_AT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .irq_en_i(irq_en_i),
  .flags_o(flags_o), .state_o(state_o), .tec_o(tec_o), .rec_o(rec_o),
  .err_irq_o(err_irq_o)
);

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       tec_inc_i = 1'b0, tec_dec_i = 1'b0, rec_inc_i = 1'b0, rec_dec_i = 1'b0;
  logic       bit_stb_i = 1'b0, bus_bit_i = 1'b1;
  logic [2:0] irq_en_i = 3'b000, flag_clr_i = 3'b000;
  logic [2:0] flags_o;
  logic [1:0] state_o;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic       err_irq_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  can_fault_conf uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .tec_inc_i(tec_inc_i), .tec_dec_i(tec_dec_i), .rec_inc_i(rec_inc_i), .rec_dec_i(rec_dec_i),
    .bit_stb_i(bit_stb_i), .bus_bit_i(bus_bit_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .flags_o(flags_o), .state_o(state_o), .tec_o(tec_o), .rec_o(rec_o), .err_irq_o(err_irq_o)
  );

  // behavioural reference
  int m_tec, m_rec, m_bitc, m_runc;
  bit m_boff;
  bit m_f[3], m_p[3];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || soft_rst_i) begin
      m_tec = 0; m_rec = 0; m_bitc = 0; m_runc = 0; m_boff = 0;
      for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_p[i] = 0; end
    end else begin
      bit done, hold;
      bit c[3];
      bit nf[3];
      int nb, nr, nt, nrc;
      done = m_boff && bit_stb_i && bus_bit_i && m_bitc == 10 && m_runc == 127;
      hold = m_boff || m_tec > 255;
      nb = m_bitc; nr = m_runc;
      if (!m_boff) begin nb = 0; nr = 0; end
      else if (bit_stb_i) begin
        if (!bus_bit_i) nb = 0;
        else if (m_bitc == 10) begin nb = 0; nr = done ? 0 : m_runc + 1; end
        else nb = m_bitc + 1;
      end
      c[0] = m_rec >= 128 && !m_f[2];
      c[1] = m_tec >= 128 && m_tec <= 255 && !m_f[2];
      c[2] = m_tec > 255;
      for (int i = 0; i < 3; i++) begin
        if (c[i] && !m_p[i]) nf[i] = 1;
        else if (flag_clr_i[i] && (i != 2 || !m_boff)) nf[i] = 0;
        else nf[i] = m_f[i];
      end
      nt = m_tec; nrc = m_rec;
      if (done) begin nt = 0; nrc = 0; end
      else if (!hold) begin
        if (tec_inc_i && !tec_dec_i && nt < 511) nt++;
        if (tec_dec_i && !tec_inc_i && nt > 0) nt--;
        if (rec_inc_i && !rec_dec_i && nrc < 255) nrc++;
        if (rec_dec_i && !rec_inc_i && nrc > 0) nrc--;
      end
      if (done) m_boff = 0;
      else if (m_tec > 255) m_boff = 1;
      m_tec = nt; m_rec = nrc; m_bitc = nb; m_runc = nr;
      for (int i = 0; i < 3; i++) begin m_f[i] = nf[i]; m_p[i] = c[i]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int ms, mi;
      ms = m_boff ? 2 : ((m_tec >= 128 || m_rec >= 128) ? 1 : 0);
      mi = ((m_f[0] && irq_en_i[0]) || (m_f[1] && irq_en_i[1]) || (m_f[2] && irq_en_i[2])) ? 1 : 0;
      chk(int'(tec_o) == m_tec, "R1 tec", int'(tec_o), m_tec);
      chk(int'(rec_o) == m_rec, "R2 rec", int'(rec_o), m_rec);
      chk(int'(state_o) == ms, "R3 state", int'(state_o), ms);
      chk(flags_o[0] == m_f[0], "R4 R7 rx flag", int'(flags_o[0]), int'(m_f[0]));
      chk(flags_o[1] == m_f[1], "R5 R7 tx flag", int'(flags_o[1]), int'(m_f[1]));
      chk(flags_o[2] == m_f[2], "R6 R8 boff flag", int'(flags_o[2]), int'(m_f[2]));
      chk(int'(err_irq_o) == mi, "R10 irq", int'(err_irq_o), mi);
    end
  end

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic pump(input int n, input bit tinc, input bit tdec, input bit rinc, input bit rdec);
    for (int i = 0; i < n; i++) begin
      tec_inc_i = tinc; tec_dec_i = tdec; rec_inc_i = rinc; rec_dec_i = rdec;
      tick();
    end
    tec_inc_i = 0; tec_dec_i = 0; rec_inc_i = 0; rec_dec_i = 0;
  endtask

  task automatic bits(input int n, input bit lvl);
    for (int i = 0; i < n; i++) begin
      bit_stb_i = 1; bus_bit_i = lvl; tick();
      bit_stb_i = 0; bus_bit_i = ~lvl; tick();
    end
    bus_bit_i = 1;
  endtask

  initial begin
    #(8 * 60000);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk(state_o == 2'd0 && flags_o == 3'b000, "R3 reset state", int'(state_o), 0);
    irq_en_i = 3'b111;

    pump(130, 0, 0, 1, 0);
    tick();
    chk(flags_o[0] == 1'b1, "R4 rx passive set", int'(flags_o[0]), 1);
    chk(err_irq_o == 1'b1, "R10 irq on", int'(err_irq_o), 1);
    irq_en_i = 3'b110; #1;
    chk(err_irq_o == 1'b0, "R10 irq masked", int'(err_irq_o), 0);
    irq_en_i = 3'b111;
    flag_clr_i = 3'b001; tick(); flag_clr_i = 3'b000;
    chk(flags_o[0] == 1'b0, "R7 w1c", int'(flags_o[0]), 0);

    pump(5, 0, 0, 0, 1);
    pump(5, 0, 0, 1, 0);
    pump(3, 1, 1, 1, 1);
    tick();
    chk(flags_o[0] == 1'b1, "R4 re-entry", int'(flags_o[0]), 1);
    pump(200, 0, 0, 1, 0);
    chk(rec_o == 8'd255, "R2 saturate", int'(rec_o), 255);

    flag_clr_i = 3'b010;
    pump(130, 1, 0, 0, 0);
    flag_clr_i = 3'b000;
    chk(flags_o[1] == 1'b0, "R7 held clear", int'(flags_o[1]), 0);
    pump(130, 1, 0, 0, 0);
    chk(state_o == 2'd2 && tec_o == 9'd256, "R1 R6 bus-off", int'(tec_o), 256);
    flag_clr_i = 3'b100; tick(); flag_clr_i = 3'b000;
    tick();
    chk(flags_o[2] == 1'b1, "R8 clear refused", int'(flags_o[2]), 1);
    pump(4, 0, 1, 0, 1);

    bits(6, 1); bits(1, 0);
    bits(4, 1); bits(1, 0);
    bits(127 * 11 + 10, 1);
    chk(state_o == 2'd2, "R9 not yet", int'(state_o), 2);
    bits(1, 1);
    chk(state_o == 2'd0 && tec_o == 9'd0 && rec_o == 8'd0, "R9 recovered", int'(state_o), 0);
    chk(flags_o[2] == 1'b1, "R7 R9 boff sticky", int'(flags_o[2]), 1);

    flag_clr_i = 3'b001; tick(); flag_clr_i = 3'b000;
    pump(130, 0, 0, 1, 0);
    tick();
    chk(flags_o[0] == 1'b0, "R4 suppressed", int'(flags_o[0]), 0);
    flag_clr_i = 3'b100; tick(); flag_clr_i = 3'b000;
    tick();
    chk(flags_o[0] == 1'b1 && flags_o[2] == 1'b0, "R4 after boff clear", int'(flags_o), 1);

    soft_rst_i = 1'b1;
    pump(5, 1, 0, 1, 0);
    chk(tec_o == 9'd0 && rec_o == 8'd0 && flags_o == 3'b000 && state_o == 2'd0,
        "R11 soft hold", int'(tec_o), 0);
    soft_rst_i = 1'b0;
    pump(3, 1, 0, 0, 0);
    chk(tec_o == 9'd3, "R11 release", int'(tec_o), 3);

    tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule